// File: doc/BRIEF.md
# Timer-Overridable Parallel Port

An 8-pin parallel I/O port sitting on a simple register bus. Each pin has a fixed role: three pins are always outputs, three are always inputs, and two are bidirectional. The bidirectional pins take their direction from two bits in a control register. Each of them can also be seized by a timer output-compare channel. While a channel is enabled, its pin is driven as an output at the level the timer supplies. The pin's direction bit is left as it is and is not consulted.

Software writes a data latch. A pin shows its latch bit only while that pin is an output and no compare owns it. The latch keeps every value written to it, including bits whose pins are inputs or are held by a compare. When a compare is released, the pin returns to whatever the latch and its direction bit select.

A read of the data address returns a mixed value. Each output bit gives the level presented to its driver, and each input bit gives the sampled pin level. Pin controls and read data are registered. A change therefore appears on the pins one clock after the state it depends on changes.

Top module: `tmr_par_port`

## Requirements
- R1: While reset is high and in the first cycle after it, pin_oe is 0x70, pin_out is 0x00 and bus_rdata is 0x00. Both direction bits reset to 0.
- R2: Pins 6..4 always have pin_oe set, whatever the control register holds. One clock after the latch changes, each of these pins drives its latch bit.
- R3: Pins 2..0 never have pin_oe set, and their pin_out bits stay 0. Data writes still store their latch bits, and those bits change nothing on these pins.
- R4: Bit 7 of the control register (address 1) sets the direction of pin 7, and bit 3 sets the direction of pin 3. A 1 makes the pin an output. With no compare active, an output pin drives its latch bit and an input pin is undriven.
- R5: While cmp_en[1] is high (the channel for pin 7) or cmp_en[0] is high (the channel for pin 3), the matching pin has pin_oe set one clock later. Its pin_out then equals that channel's cmp_lvl bit.
- R6: While a compare owns a pin, data writes do not change that pin. The latch still stores the written bit, and the pin drives it once the compare is disabled and the direction bit is 1.
- R7: A read of the data address (0) returns, one clock later, the current pin_out bit for each pin with pin_oe set and the pin_in bit for every other pin. bus_rdata holds its value until the next read.
- R8: A read of the control address returns the two direction bits at bit positions 7 and 3, with 0 in all other bits.
- R9: Enabling or disabling a compare never changes the stored direction bits. One clock after a compare is disabled, the direction bit again decides the pin's direction.
- R10: A pin_out bit is 0 whenever the matching pin_oe bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | 0 = data latch, 1 = control register |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Registered read data |
| cmp_en | input | 2 | Compare enable: bit 1 is the channel for pin 7, bit 0 the channel for pin 3 |
| cmp_lvl | input | 2 | Compare output level for each channel |
| pin_in | input | W | Sampled pad levels |
| pin_oe | output | W | Per-pin driver enable |
| pin_out | output | W | Per-pin driven level |

## Verification
The assertions check on every cycle that the fixed roles hold: pins 6..4 are always enabled, pins 2..0 are never enabled, and an undriven pin always carries 0. They also check that an enabled compare takes its pin one clock later at the timer's level, and that a released pin falls back to its stored direction bit. The latch and the read data must stay stable when no write or read is addressed to them. Only the bench scenarios can show the data path from bus to pin and back. That covers a write made while a compare is active, which must stay off the pin but reappear when the compare is released. It also covers the mixed read-back of input and output bits, and the position of the direction bits on a control read.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_WR_DATA = 2'd1,
    OP_WR_CTRL = 2'd2,
    OP_RD      = 2'd3
  } bus_op_e;

  localparam int unsigned NCMP = 2;
endpackage

// File: rtl/tpp_regs.sv
module tpp_regs
  import tpp_pkg::*;
#(
  parameter int unsigned W         = 8,
  parameter int unsigned ADDR_W    = 1,
  parameter int unsigned DATA_ADDR = 0,
  parameter int unsigned CTRL_ADDR = 1,
  parameter int unsigned CMP_PIN0  = 3,
  parameter int unsigned CMP_PIN1  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output bus_op_e           op,
  output logic              rd_ctrl,
  output logic [W-1:0]      latch,
  output logic [NCMP-1:0]   dir
);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_ADDR);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

  always_comb begin
    op      = OP_IDLE;
    rd_ctrl = 1'b0;
    if (sel) begin
      if (!wr) begin
        op      = OP_RD;
        rd_ctrl = (addr == A_CTRL);
      end else if (addr == A_DATA) begin
        op = OP_WR_DATA;
      end else if (addr == A_CTRL) begin
        op = OP_WR_CTRL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
      dir   <= '0;
    end else begin
      if (op == OP_WR_DATA) latch <= wdata;
      if (op == OP_WR_CTRL) dir <= {wdata[CMP_PIN1], wdata[CMP_PIN0]};
    end
  end

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (op != OP_WR_DATA) |=> $stable(latch));

  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (op != OP_WR_CTRL) |=> $stable(dir));
endmodule

// File: rtl/tpp_pin_ctrl.sv
module tpp_pin_ctrl
  import tpp_pkg::*;
#(
  parameter int unsigned W          = 8,
  parameter logic [W-1:0] OUT_MASK  = 8'h70,
  parameter int unsigned CMP_PIN0   = 3,
  parameter int unsigned CMP_PIN1   = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    latch,
  input  logic [NCMP-1:0] dir,
  input  logic [NCMP-1:0] cmp_en,
  input  logic [NCMP-1:0] cmp_lvl,
  output logic [W-1:0]    pin_oe,
  output logic [W-1:0]    pin_out
);
  logic [W-1:0] oe_n;
  logic [W-1:0] out_n;

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i == CMP_PIN0 || i == CMP_PIN1) begin : g_shared
      localparam int unsigned C = (i == CMP_PIN1) ? 1 : 0;
      assign oe_n[i]  = cmp_en[C] | dir[C];
      assign out_n[i] = oe_n[i] & (cmp_en[C] ? cmp_lvl[C] : latch[i]);

      assert_cmp_force_R5: assert property (@(posedge clk) disable iff (rst)
        cmp_en[C] |=> (pin_oe[i] && (pin_out[i] == $past(cmp_lvl[C]))));

      assert_dir_back_R9: assert property (@(posedge clk) disable iff (rst)
        !cmp_en[C] |=> (pin_oe[i] == $past(dir[C])));
    end else if (OUT_MASK[i]) begin : g_fixed_out
      assign oe_n[i]  = 1'b1;
      assign out_n[i] = latch[i];

      assert_fixed_out_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pin_oe[i] && (pin_out[i] == $past(latch[i]))));
    end else begin : g_fixed_in
      assign oe_n[i]  = 1'b0;
      assign out_n[i] = oe_n[i] & latch[i];

      assert_in_only_R3: assert property (@(posedge clk) disable iff (rst)
        (!pin_oe[i] && !pin_out[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_oe  <= OUT_MASK;
      pin_out <= '0;
    end else begin
      pin_oe  <= oe_n;
      pin_out <= out_n;
    end
  end

  assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    ((pin_out & ~pin_oe) == '0));
endmodule

// File: rtl/tpp_readback.sv
module tpp_readback
  import tpp_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter int unsigned CMP_PIN0 = 3,
  parameter int unsigned CMP_PIN1 = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  bus_op_e         op,
  input  logic            rd_ctrl,
  input  logic [W-1:0]    pin_oe,
  input  logic [W-1:0]    pin_out,
  input  logic [W-1:0]    pin_in,
  input  logic [NCMP-1:0] dir,
  output logic [W-1:0]    rdata
);
  logic [W-1:0] data_view;
  logic [W-1:0] ctrl_view;

  always_comb begin
    data_view = (pin_oe & pin_out) | (~pin_oe & pin_in);
    ctrl_view = '0;
    ctrl_view[CMP_PIN0] = dir[0];
    ctrl_view[CMP_PIN1] = dir[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (op == OP_RD) begin
      rdata <= rd_ctrl ? ctrl_view : data_view;
    end
  end

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (op != OP_RD) |=> $stable(rdata));
endmodule

// File: rtl/tmr_par_port.sv
module tmr_par_port
  import tpp_pkg::*;
#(
  parameter int unsigned  W         = 8,
  parameter int unsigned  ADDR_W    = 1,
  parameter int unsigned  DATA_ADDR = 0,
  parameter int unsigned  CTRL_ADDR = 1,
  parameter logic [W-1:0] OUT_MASK  = 8'h70,
  parameter int unsigned  CMP_PIN0  = 3,
  parameter int unsigned  CMP_PIN1  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [1:0]        cmp_en,
  input  logic [1:0]        cmp_lvl,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_out
);
  bus_op_e         op;
  logic            rd_ctrl;
  logic [W-1:0]    latch;
  logic [NCMP-1:0] dir;

  tpp_regs #(
    .W(W), .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .CMP_PIN0(CMP_PIN0), .CMP_PIN1(CMP_PIN1)
  ) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .op(op), .rd_ctrl(rd_ctrl), .latch(latch), .dir(dir)
  );

  tpp_pin_ctrl #(
    .W(W), .OUT_MASK(OUT_MASK), .CMP_PIN0(CMP_PIN0), .CMP_PIN1(CMP_PIN1)
  ) u_pins (
    .clk(clk), .rst(rst), .latch(latch), .dir(dir), .cmp_en(cmp_en),
    .cmp_lvl(cmp_lvl), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  tpp_readback #(
    .W(W), .CMP_PIN0(CMP_PIN0), .CMP_PIN1(CMP_PIN1)
  ) u_rb (
    .clk(clk), .rst(rst), .op(op), .rd_ctrl(rd_ctrl), .pin_oe(pin_oe),
    .pin_out(pin_out), .pin_in(pin_in), .dir(dir), .rdata(bus_rdata)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> ((pin_oe == OUT_MASK) && (pin_out == '0) && (bus_rdata == '0)));
endmodule

// File: tb/tmr_par_port_tb.sv
module tmr_par_port_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel = 1'b0, wr = 1'b0;
  logic [0:0] addr = 1'b0;
  logic [7:0] wdata = '0, pin_in = '0;
  logic [1:0] cmp_en = '0, cmp_lvl = '0;
  logic [7:0] rdata, pin_oe, pin_out;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_latch = '0;
  logic [1:0] m_dir = '0;

  always #4 clk = ~clk;

  tmr_par_port u_dut (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .cmp_en(cmp_en), .cmp_lvl(cmp_lvl),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  function automatic logic [7:0] f_oe(input logic [1:0] d, input logic [1:0] ce);
    logic [7:0] v = 8'h70;
    v[3] = ce[0] | d[0];
    v[7] = ce[1] | d[1];
    return v;
  endfunction

  function automatic logic [7:0] f_out(input logic [7:0] l, input logic [1:0] d,
                                       input logic [1:0] ce, input logic [1:0] lv);
    logic [7:0] v = l & 8'h70;
    v[3] = ce[0] ? lv[0] : (d[0] & l[3]);
    v[7] = ce[1] ? lv[1] : (d[1] & l[7]);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
    if (a == 1'b0) m_latch = d; else m_dir = {d[7], d[3]};
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk); sel = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic check_pins(input string tag);
    chk({tag, " oe"}, pin_oe, f_oe(m_dir, cmp_en));
    chk({tag, " out"}, pin_out, f_out(m_latch, m_dir, cmp_en, cmp_lvl));
  endtask

  function automatic logic [7:0] exp_data();
    logic [7:0] oe = f_oe(m_dir, cmp_en);
    return (oe & f_out(m_latch, m_dir, cmp_en, cmp_lvl)) | (~oe & pin_in);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk("R1 reset oe", pin_oe, 8'h70);
    chk("R1 reset out", pin_out, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post oe", pin_oe, 8'h70);
    chk("R1 post out", pin_out, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    bus_read(1'b1, rv);
    chk("R1 dir reset", rv, 8'h00);

    // R2 / R3: fixed pins ignore direction settings
    bus_write(1'b1, 8'hFF);
    bus_write(1'b1, 8'h00);
    bus_write(1'b0, 8'hFF);
    settle();
    check_pins("R2_R3 all ones");
    chk("R3 inputs undriven", pin_oe & 8'h07, 8'h00);
    pin_in = 8'h5A;
    bus_read(1'b0, rv);
    chk("R7 mixed read", rv, exp_data());

    // R4: bidirectional direction bits
    bus_write(1'b1, 8'h88);
    settle();
    check_pins("R4 both out");
    chk("R4 pin7 drives latch", pin_out & 8'h88, 8'h88);
    bus_read(1'b1, rv);
    chk("R8 ctrl read", rv, 8'h88);

    // R5 / R6: compare override while writes happen
    bus_write(1'b0, 8'h00);
    @(negedge clk); cmp_en = 2'b11; cmp_lvl = 2'b10;
    settle();
    check_pins("R5 override");
    chk("R5 pin7 level", pin_out & 8'h88, 8'h80);
    bus_write(1'b0, 8'hFF);
    settle();
    chk("R6 write ignored", pin_out & 8'h88, 8'h80);
    check_pins("R6 during override");
    @(negedge clk); cmp_en = 2'b00;
    settle();
    chk("R6 restored", pin_out, 8'hF8);
    bus_read(1'b1, rv);
    chk("R9 dir untouched", rv, 8'h88);

    // R9: compare released with direction input
    bus_write(1'b1, 8'h00);
    @(negedge clk); cmp_en = 2'b01; cmp_lvl = 2'b01;
    settle();
    check_pins("R9 pin3 forced");
    @(negedge clk); cmp_en = 2'b00;
    settle();
    check_pins("R9 back to input");
    chk("R10 idle zero", pin_out & ~pin_oe, 8'h00);
    pin_in = 8'hA5;
    bus_read(1'b0, rv);
    chk("R7 inputs read", rv, 8'hF5);

    // R7 hold across non-read cycles
    held = rdata;
    bus_write(1'b0, 8'h0F);
    pin_in = 8'h3C;
    settle();
    chk("R7 hold", rdata, held);

    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      op = $urandom_range(0, 4);
      case (op)
        0, 4: bus_write(1'b0, 8'($urandom));
        1: bus_write(1'b1, 8'($urandom));
        2: begin
          @(negedge clk);
          cmp_en = 2'($urandom);
          cmp_lvl = 2'($urandom);
        end
        default: begin
          @(negedge clk);
          pin_in = 8'($urandom);
        end
      endcase
      settle();
      check_pins("R2_R4_R5 random");
      bus_read(1'b0, rv);
      chk("R7 random read", rv, exp_data());
      if ((it % 4) == 0) begin
        bus_read(1'b1, rv);
        chk("R8 random ctrl", rv, {m_dir[1], 3'b000, m_dir[0], 3'b000});
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule